// File: doc/BRIEF.md
# Serial Flash Page-Size Configuration Sequencer

This block is a host-side controller that switches an attached serial flash to its alternate page-size setting. A single start pulse makes it send a fixed four-byte configuration command over a four-wire serial link (active-low select, serial clock, host-out and host-in data). It then releases select so that the flash runs its self-timed programming cycle. After a minimum wait it reads the flash status byte repeatedly until the device reports ready.

Once the flash is ready, the block checks the page-size flag in the status byte. If the flag is clear, the block sends the whole command again. The number of command attempts is bounded by a parameter. The outcome is reported as a one-cycle `done` pulse or a one-cycle `fail` pulse. `busy` covers the whole operation.

The serial clock is the system clock divided by `2*CLK_DIV`. The status-read opcode, the minimum programming wait and the attempt limit are parameters.

Top module: `flash_pgsz_seq`

## Requirements
- R1: A command frame carries exactly 32 bits, the bytes 0x3D, 0x2A, 0x80 and 0xA6 in that order, each byte most-significant bit first, all inside one low period of `spi_cs_n`.
- R2: `spi_sclk` is high whenever `spi_cs_n` is high. `spi_cs_n` falls while `spi_sclk` is high. Each serial clock half period lasts `CLK_DIV` system cycles.
- R3: `spi_mosi` changes only in the cycle in which `spi_sclk` falls, so it is stable across every rising edge of `spi_sclk`.
- R4: `spi_cs_n` rises only after the rising serial clock edge of the last bit of a frame. No serial clock edge occurs while `spi_cs_n` is high.
- R5: After a command frame ends, `spi_cs_n` stays high for at least `WAIT_CYCLES` system cycles before the first status frame.
- R6: A status frame carries 16 bits: the `STATUS_OP` opcode MSB first, then eight zero bits. During those eight bits the status byte is captured from `spi_miso` MSB first on rising serial clock edges.
- R7: A status byte with bit 7 = 0 (not ready) causes another status frame and no command frame, whatever bit 0 holds.
- R8: A status byte with bit 7 = 1 and bit 0 = 1 ends the operation. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: A status byte with bit 7 = 1 and bit 0 = 0 causes the full command frame to be sent again. After `MAX_TRIES` command frames have each been verified with bit 0 = 0, `fail` pulses for one cycle, `busy` drops and no further frame is sent.
- R10: `start` has no effect while `busy` is high: no extra frames and no extra `done` or `fail` pulses result.
- R11: After reset, `spi_cs_n` and `spi_sclk` are high and `busy`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the configuration sequence (ignored while busy) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: page-size flag verified |
| fail | output | 1 | One-cycle pulse: attempt limit reached |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Host-to-flash serial data |
| spi_miso | input | 1 | Flash-to-host serial data |

## Verification
The assertions check on every cycle that the serial clock idles high while select is high, and that host data moves only on falling clock edges. They also check that select rises only after a completed byte, that `done` lasts one cycle and clears `busy`, and that the attempt counter stays inside its limit. Only the bench's scenarios can show the rest. Those are the exact bit content of each frame and the length of the programming wait. They also cover the decision made from each status byte: a not-ready byte with bit 0 set, a ready byte with the flag clear that leads to a resend, and attempt exhaustion. The bench also shows that a start pulse arriving mid-operation leaves the frame stream unchanged.

// File: rtl/pgsz_pkg.sv
package pgsz_pkg;

  localparam int unsigned CMD_BYTES = 4;
  localparam logic [31:0] CMD_WORD = 32'h3D2A_80A6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_WAIT,
    S_POLL,
    S_EVAL
  } seq_state_t;

  function automatic logic [7:0] cmd_byte(input logic [1:0] idx);
    return CMD_WORD[8*(3-int'(idx)) +: 8];
  endfunction

endpackage

// File: rtl/pgsz_tick.sv
module pgsz_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/pgsz_byte_shift.sv
module pgsz_byte_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic [7:0] sh;
  logic [2:0] bitc;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      byte_done <= 1'b0;
      sh        <= '0;
      rx        <= '0;
      bitc      <= '0;
      sclk_o    <= 1'b1;
      mosi_o    <= 1'b1;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        sclk_o <= 1'b1;
        if (go) begin
          active <= 1'b1;
          sh     <= tx;
          bitc   <= '0;
        end
      end else if (tick) begin
        if (sclk_o) begin
          sclk_o <= 1'b0;
          mosi_o <= sh[7];
        end else begin
          sclk_o <= 1'b1;
          rx     <= {rx[6:0], miso};
          sh     <= {sh[6:0], 1'b0};
          bitc   <= bitc + 1'b1;
          if (bitc == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end
        end
      end
    end
  end

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$fell(sclk_o) |-> $stable(mosi_o)); // R3

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |=> sclk_o || active); // R2

endmodule

// File: rtl/flash_pgsz_seq.sv
module flash_pgsz_seq #(
  parameter int unsigned CLK_DIV     = 4,
  parameter logic [7:0]  STATUS_OP   = 8'hD7,
  parameter int unsigned WAIT_CYCLES = 5000,
  parameter int unsigned MAX_TRIES   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic fail,
  output logic spi_cs_n,
  output logic spi_sclk,
  output logic spi_mosi,
  input  logic spi_miso
);
  import pgsz_pkg::*;

  localparam int unsigned WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam int unsigned TRY_W  = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

  seq_state_t        state;
  logic [1:0]        idx;
  logic [TRY_W-1:0]  tries;
  logic [WAIT_W-1:0] wcnt;
  logic [7:0]        stat;
  logic              sh_go;
  logic [7:0]        sh_tx;
  logic              sh_active;
  logic              sh_done;
  logic [7:0]        sh_rx;
  logic              tick;

  pgsz_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (sh_active),
    .tick (tick)
  );

  pgsz_byte_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .go        (sh_go),
    .tx        (sh_tx),
    .tick      (tick),
    .miso      (spi_miso),
    .active    (sh_active),
    .byte_done (sh_done),
    .rx        (sh_rx),
    .sclk_o    (spi_sclk),
    .mosi_o    (spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      spi_cs_n <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      sh_go    <= 1'b0;
      sh_tx    <= '0;
      idx      <= '0;
      tries    <= '0;
      wcnt     <= '0;
      stat     <= '0;
    end else begin
      done  <= 1'b0;
      fail  <= 1'b0;
      sh_go <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            tries    <= '0;
            spi_cs_n <= 1'b0;
            idx      <= '0;
            sh_go    <= 1'b1;
            sh_tx    <= cmd_byte(2'd0);
            state    <= S_CMD;
          end
        end
        S_CMD: begin
          if (sh_done) begin
            if (idx == 2'(CMD_BYTES - 1)) begin
              spi_cs_n <= 1'b1;
              wcnt     <= WAIT_W'(WAIT_CYCLES);
              state    <= S_WAIT;
            end else begin
              idx   <= idx + 2'd1;
              sh_go <= 1'b1;
              sh_tx <= cmd_byte(idx + 2'd1);
            end
          end
        end
        S_WAIT: begin
          if (wcnt == '0) begin
            spi_cs_n <= 1'b0;
            idx      <= '0;
            sh_go    <= 1'b1;
            sh_tx    <= STATUS_OP;
            state    <= S_POLL;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_POLL: begin
          if (sh_done) begin
            if (idx == 2'd0) begin
              idx   <= 2'd1;
              sh_go <= 1'b1;
              sh_tx <= 8'h00;
            end else begin
              spi_cs_n <= 1'b1;
              stat     <= sh_rx;
              state    <= S_EVAL;
            end
          end
        end
        S_EVAL: begin
          if (!stat[7]) begin
            spi_cs_n <= 1'b0;
            idx      <= '0;
            sh_go    <= 1'b1;
            sh_tx    <= STATUS_OP;
            state    <= S_POLL;
          end else if (stat[0]) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (tries == TRY_LAST) begin
            fail  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            tries    <= tries + 1'b1;
            spi_cs_n <= 1'b0;
            idx      <= '0;
            sh_go    <= 1'b1;
            sh_tx    <= cmd_byte(2'd0);
            state    <= S_CMD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CS_HIGH_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> spi_sclk); // R2

  AST_CS_RISE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> $past(sh_done)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy); // R8

  AST_NOT_DONE_AND_FAIL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R9

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (rst)
    tries <= TRY_LAST); // R9

endmodule

// File: tb/flash_pgsz_seq_tb.sv
module flash_pgsz_seq_tb;
  localparam int unsigned CLK_DIV     = 2;
  localparam logic [7:0]  STATUS_OP   = 8'hD7;
  localparam int unsigned WAIT_CYCLES = 20;
  localparam int unsigned MAX_TRIES   = 3;
  localparam logic [39:0] EXP_CMD  = {8'd32, 32'h3D2A80A6};
  localparam logic [39:0] EXP_POLL = {8'd16, 16'h0000, STATUS_OP, 8'h00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, fail, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b1;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  int fail_cnt = 0;
  int stray = 0;

  logic [39:0] exp_q[$];

  // flash model configuration
  int busy_polls = 0;
  int fail_first = 0;
  int attempt = 0;
  int busy_left = 0;

  always #4 clk = ~clk;

  flash_pgsz_seq #(
    .CLK_DIV(CLK_DIV), .STATUS_OP(STATUS_OP),
    .WAIT_CYCLES(WAIT_CYCLES), .MAX_TRIES(MAX_TRIES)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        done_cnt++;
        check(busy == 1'b0, "R8", "busy low with done", busy, 0);
      end
      if (fail) begin
        fail_cnt++;
        check(busy == 1'b0, "R9", "busy low with fail", busy, 0);
      end
      if (spi_cs_n && !spi_sclk) stray++;
    end
  end

  // flash model and frame scoreboard
  initial begin
    logic pcs, psclk, in_frame, last_cmd;
    logic [31:0] bits;
    logic [7:0] resp;
    logic [39:0] e;
    int nb, cmd_end;
    pcs = 1'b1; psclk = 1'b1; in_frame = 1'b0; last_cmd = 1'b0;
    bits = '0; resp = '0; nb = 0; cmd_end = 0;
    forever begin
      @(spi_cs_n or spi_sclk);
      if (!rst) begin
        if (pcs && !spi_cs_n) begin
          in_frame = 1'b1; nb = 0; bits = '0;
          check(spi_sclk == 1'b1, "R2", "sclk high at select fall", spi_sclk, 1);
          if (last_cmd) begin
            check(cyc - cmd_end >= WAIT_CYCLES, "R5", "wait before first poll",
                  cyc - cmd_end, WAIT_CYCLES);
            last_cmd = 1'b0;
          end
          if (busy_left > 0) resp = 8'h41;
          else resp = (attempt > fail_first) ? 8'hA5 : 8'hA4;
        end else if (!pcs && spi_cs_n && in_frame) begin
          in_frame = 1'b0;
          spi_miso = 1'b1;
          check(spi_sclk == 1'b1, "R4", "sclk high at select rise", spi_sclk, 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected frame", {nb[7:0], bits}, 0);
          end else begin
            e = exp_q.pop_front();
            check({nb[7:0], bits} == e, (e == EXP_CMD) ? "R1" : "R6",
                  "frame content", {nb[7:0], bits}, e);
          end
          if (nb == 32 && bits == 32'h3D2A80A6) begin
            attempt++; busy_left = busy_polls; last_cmd = 1'b1; cmd_end = cyc;
          end else if (nb == 16 && busy_left > 0) begin
            busy_left--;
          end
        end else if (in_frame && !psclk && spi_sclk) begin
          bits = {bits[30:0], spi_mosi};
          nb++;
        end else if (in_frame && psclk && !spi_sclk) begin
          if (nb >= 8 && nb < 16) spi_miso = resp[15-nb];
        end
      end
      pcs = spi_cs_n; psclk = spi_sclk;
    end
  end

  task automatic run_case(input int bp, input int ff, input int attempts,
                          input bit pass, input bit extra_start);
    int d0, f0, t;
    d0 = done_cnt; f0 = fail_cnt;
    busy_polls = bp; fail_first = ff; attempt = 0; busy_left = 0;
    for (int a = 0; a < attempts; a++) begin
      exp_q.push_back(EXP_CMD);
      for (int p = 0; p <= bp; p++) exp_q.push_back(EXP_POLL);
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (extra_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (WAIT_CYCLES + 70) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && fail_cnt == f0 && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (300) @(negedge clk);
    check(done_cnt - d0 == int'(pass), "R8", "done pulses", done_cnt - d0, int'(pass));
    check(fail_cnt - f0 == int'(!pass), "R9", "fail pulses", fail_cnt - f0, int'(!pass));
    check(exp_q.size() == 0, pass ? "R7" : "R9", "frames left unsent", exp_q.size(), 0);
    check(busy == 1'b0, "R10", "idle at end", busy, 0);
    exp_q.delete();
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1, "R11", "cs_n reset", spi_cs_n, 1);
        check(spi_sclk == 1'b1, "R11", "sclk reset", spi_sclk, 1);
        check({busy, done, fail} == 3'b000, "R11", "flags reset", {busy, done, fail}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // immediate pass, no busy polls
        run_case(0, 0, 1, 1'b1, 1'b0);
        // busy polls (bit 0 set while not ready) then pass, extra starts ignored
        run_case(2, 0, 1, 1'b1, 1'b1);
        // flag clear once, resend, then pass
        run_case(1, 1, 2, 1'b1, 1'b0);
        // flag never set: attempt limit
        run_case(0, 99, MAX_TRIES, 1'b0, 1'b0);
        check(stray == 0, "R2", "sclk low while deselected", stray, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule